// File: doc/BRIEF.md
# Three-Wire Serial Register Port

This block is the slave side of a three-wire control port. A host drives a serial clock, a frame line that is low while a transfer is in progress, and a data line. Through this port the host reads and writes eight 8-bit control registers: one operating-mode register, one channel-order register, three per-colour gain registers and three per-colour offset registers. All eight registers are also available as parallel outputs. The bits of the mode register are decoded into individual mode flags for the rest of the chip.

The serial pins are asynchronous to the chip clock. Each pin passes through a two-stage synchronizer, and the block then finds the serial clock and frame edges in the chip clock domain. The shared data pin is split into an input, an output and an output-enable, so the pad logic can combine them. A frame is 16 serial clock pulses. The block acts only on register contents and frame timing; how the gain and offset values are used is outside this block.

Top module: `serreg_port`

## Requirements
- R1: After reset, the mode register holds 0x34, the channel-order register holds 0x21, and the six gain and offset registers hold 0x00. The data output-enable is low.
- R2: The block samples the data line on rising serial clock edges while the frame line is low. Frame bit 1 is the direction flag (0 = write, 1 = read). Bits 2 to 4 are the register address, most significant bit first. Bits 5 to 8 are ignored filler. Bits 9 to 16 are the data byte, most significant bit first.
- R3: A write frame does not change any register while the frame line is still low. The addressed register takes the data byte only when the frame line rises.
- R4: Address 0 selects the mode register and address 1 the channel-order register. Addresses 2, 3 and 4 select the red, green and blue gain registers. Addresses 5, 6 and 7 select the red, green and blue offset registers.
- R5: Rising serial clock edges after the sixteenth in a frame are ignored. A write frame with extra pulses stores the byte carried in bits 9 to 16.
- R6: If the frame line rises after fewer than 16 rising serial clock edges, no register changes.
- R7: In a read frame, the output-enable stays low before the eighth falling serial clock edge. From that edge on, the block drives the addressed register most significant bit first, and a new bit follows each falling edge, so the host samples data bit 7 down to 0 on rising edges 9 to 16.
- R8: The output-enable is low whenever the frame line is high.
- R9: The mode flags follow mode register bits as follows: bit 5 selects correlated sampling, bit 4 the wide span, bit 3 the narrow span, bit 2 three-channel mode and bit 1 single-channel mode.
- R10: A read frame leaves every register unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Chip clock; must be well above twice the serial clock rate |
| rstN | input | 1 | Active-low asynchronous reset |
| serClk | input | 1 | Serial clock from the host |
| serLoad | input | 1 | Frame line, low during a transfer |
| serDataIn | input | 1 | Data line as seen from the pad |
| serDataOut | output | 1 | Read data toward the pad |
| serDataOe | output | 1 | Pad drive enable for serDataOut |
| cfgReg | output | 8 | Mode register contents |
| muxReg | output | 8 | Channel-order register contents |
| gainRed | output | 8 | Red gain register |
| gainGreen | output | 8 | Green gain register |
| gainBlue | output | 8 | Blue gain register |
| offsetRed | output | 8 | Red offset register |
| offsetGreen | output | 8 | Green offset register |
| offsetBlue | output | 8 | Blue offset register |
| modeCorrSample | output | 1 | Correlated sampling selected |
| modeSpanWide | output | 1 | Wide input span selected |
| modeSpanNarrow | output | 1 | Narrow input span selected |
| modeTriChannel | output | 1 | Three-channel mode selected |
| modeSingleChannel | output | 1 | Single-channel mode selected |

## Verification
The assertions take three things for granted about the inputs. Each serial clock level and frame level lasts several chip clocks. The data line is stable around every rising serial clock edge. The frame line never changes in the same chip cycle as a serial clock edge. The stimulus holds every serial level for ten chip clocks. It changes the data line only while the serial clock is low, and it moves the frame line only with the serial clock low and a half period away from any serial edge. Random frames vary the direction, address, data and pulse count, including short and over-long frames.

// File: rtl/serreg_pkg.sv
package serreg_pkg;

  typedef struct packed {
    logic shiftIn;
    logic captureRw;
    logic captureAddr;
    logic loadRead;
    logic shiftRead;
    logic commit;
    logic driveEn;
  } serStrobes_t;

  function automatic logic [7:0] regResetValue(input int idx);
    case (idx)
      0:       return 8'h34;
      1:       return 8'h21;
      default: return 8'h00;
    endcase
  endfunction

endpackage

// File: rtl/serreg_sync.sv
module serreg_sync #(
  parameter int STAGES  = 2,
  parameter bit RST_VAL = 1'b0
) (
  input  logic clk,
  input  logic rstN,
  input  logic din,
  output logic dout
);
  logic [STAGES-1:0] pipe;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) pipe <= {STAGES{RST_VAL}};
    else       pipe <= {pipe[STAGES-2:0], din};
  end

  assign dout = pipe[STAGES-1];
endmodule

// File: rtl/serreg_ctrl.sv
module serreg_ctrl
  import serreg_pkg::*;
#(
  parameter int FRAME_BITS = 16,
  parameter int ADDR_W     = 3,
  parameter int REG_W      = 8
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        sclkS,
  input  logic        loadS,
  input  logic        rwFlag,
  output serStrobes_t str
);
  localparam int CNT_W   = $clog2(FRAME_BITS + 1);
  localparam int RD_FALL = FRAME_BITS - REG_W;

  logic             sclkPrev, loadPrev;
  logic [CNT_W-1:0] bitCnt, fallCnt;
  logic             driveEn;
  logic             sclkRise, sclkFall, loadRise, active;
  logic             acceptBit, fallEvent;

  assign sclkRise  = sclkS & ~sclkPrev;
  assign sclkFall  = ~sclkS & sclkPrev;
  assign loadRise  = loadS & ~loadPrev;
  assign active    = ~loadS;
  assign acceptBit = sclkRise && active && (bitCnt < CNT_W'(FRAME_BITS));
  assign fallEvent = sclkFall && active && (fallCnt < CNT_W'(FRAME_BITS));

  always_comb begin
    str             = '0;
    str.shiftIn     = acceptBit;
    str.captureRw   = acceptBit && (bitCnt == '0);
    str.captureAddr = acceptBit && (bitCnt >= CNT_W'(1)) && (bitCnt <= CNT_W'(ADDR_W));
    str.loadRead    = fallEvent && rwFlag && (fallCnt == CNT_W'(RD_FALL - 1));
    str.shiftRead   = fallEvent && rwFlag && driveEn && (fallCnt >= CNT_W'(RD_FALL));
    str.commit      = loadRise && !rwFlag && (bitCnt == CNT_W'(FRAME_BITS));
    str.driveEn     = driveEn;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      sclkPrev <= 1'b0;
      loadPrev <= 1'b1;
      bitCnt   <= '0;
      fallCnt  <= '0;
      driveEn  <= 1'b0;
    end else begin
      sclkPrev <= sclkS;
      loadPrev <= loadS;
      if (loadS) begin
        bitCnt  <= '0;
        fallCnt <= '0;
        driveEn <= 1'b0;
      end else begin
        if (acceptBit)    bitCnt  <= bitCnt + 1'b1;
        if (fallEvent)    fallCnt <= fallCnt + 1'b1;
        if (str.loadRead) driveEn <= 1'b1;
      end
    end
  end

  // R5: the bit counter never passes the frame length
  assert_bitcnt_bound_R5: assert property (@(posedge clk) disable iff (!rstN)
    bitCnt <= CNT_W'(FRAME_BITS));

  // R8: drive is dropped once the frame line is high
  assert_no_drive_idle_R8: assert property (@(posedge clk) disable iff (!rstN)
    loadS |=> !driveEn);

  // R7: drive starts only at the read start falling edge
  assert_drive_start_R7: assert property (@(posedge clk) disable iff (!rstN)
    $rose(driveEn) |-> (fallCnt == CNT_W'(RD_FALL)));

  // R2: strobes of separate edge kinds never coincide
  assert_strobe_exclusive_R2: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({str.commit, str.loadRead, str.shiftIn}));
endmodule

// File: rtl/serreg_dp.sv
module serreg_dp
  import serreg_pkg::*;
#(
  parameter int ADDR_W = 3,
  parameter int REG_W  = 8
) (
  input  logic                          clk,
  input  logic                          rstN,
  input  serStrobes_t                   str,
  input  logic                          sdataS,
  output logic                          rwFlag,
  output logic                          serOut,
  output logic [(1<<ADDR_W)*REG_W-1:0]  regFlat
);
  localparam int NUM_REGS = 1 << ADDR_W;

  logic [ADDR_W-1:0] addrReg;
  logic [REG_W-1:0]  inShift, rdShift;
  logic [REG_W-1:0]  regFile [NUM_REGS];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rwFlag  <= 1'b0;
      addrReg <= '0;
      inShift <= '0;
      rdShift <= '0;
    end else begin
      if (str.captureRw)   rwFlag  <= sdataS;
      if (str.captureAddr) addrReg <= {addrReg[ADDR_W-2:0], sdataS};
      if (str.shiftIn)     inShift <= {inShift[REG_W-2:0], sdataS};
      if (str.loadRead)       rdShift <= regFile[addrReg];
      else if (str.shiftRead) rdShift <= {rdShift[REG_W-2:0], 1'b0};
    end
  end

  assign serOut = rdShift[REG_W-1];

  for (genvar g = 0; g < NUM_REGS; g++) begin : gRegs
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN)
        regFile[g] <= REG_W'(regResetValue(g));
      else if (str.commit && (addrReg == ADDR_W'(g)))
        regFile[g] <= inShift;
    end
    assign regFlat[g*REG_W +: REG_W] = regFile[g];

    // R3: a register moves only on a commit strobe
    assert_hold_without_commit_R3: assert property (@(posedge clk) disable iff (!rstN)
      !str.commit |=> $stable(regFile[g]));
  end
endmodule

// File: rtl/serreg_port.sv
module serreg_port
  import serreg_pkg::*;
#(
  parameter int FRAME_BITS  = 16,
  parameter int REG_W       = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             serClk,
  input  logic             serLoad,
  input  logic             serDataIn,
  output logic             serDataOut,
  output logic             serDataOe,
  output logic [REG_W-1:0] cfgReg,
  output logic [REG_W-1:0] muxReg,
  output logic [REG_W-1:0] gainRed,
  output logic [REG_W-1:0] gainGreen,
  output logic [REG_W-1:0] gainBlue,
  output logic [REG_W-1:0] offsetRed,
  output logic [REG_W-1:0] offsetGreen,
  output logic [REG_W-1:0] offsetBlue,
  output logic             modeCorrSample,
  output logic             modeSpanWide,
  output logic             modeSpanNarrow,
  output logic             modeTriChannel,
  output logic             modeSingleChannel
);
  localparam int ADDR_W       = 3;
  localparam int NUM_REGS     = 1 << ADDR_W;
  localparam int BIT_CORR     = 5;
  localparam int BIT_WIDE     = 4;
  localparam int BIT_NARROW   = 3;
  localparam int BIT_TRI      = 2;
  localparam int BIT_SINGLE   = 1;

  logic        sclkS, loadS, sdataS, rwFlag, serOut;
  serStrobes_t str;
  logic [NUM_REGS*REG_W-1:0] regFlat;

  serreg_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b0)) i_syncClk
    (.clk(clk), .rstN(rstN), .din(serClk), .dout(sclkS));
  serreg_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) i_syncLoad
    (.clk(clk), .rstN(rstN), .din(serLoad), .dout(loadS));
  serreg_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b0)) i_syncData
    (.clk(clk), .rstN(rstN), .din(serDataIn), .dout(sdataS));

  serreg_ctrl #(.FRAME_BITS(FRAME_BITS), .ADDR_W(ADDR_W), .REG_W(REG_W)) i_ctrl (
    .clk(clk), .rstN(rstN), .sclkS(sclkS), .loadS(loadS), .rwFlag(rwFlag), .str(str)
  );

  serreg_dp #(.ADDR_W(ADDR_W), .REG_W(REG_W)) i_dp (
    .clk(clk), .rstN(rstN), .str(str), .sdataS(sdataS),
    .rwFlag(rwFlag), .serOut(serOut), .regFlat(regFlat)
  );

  assign serDataOe  = str.driveEn;
  assign serDataOut = serOut & str.driveEn;

  assign cfgReg      = regFlat[0*REG_W +: REG_W];
  assign muxReg      = regFlat[1*REG_W +: REG_W];
  assign gainRed     = regFlat[2*REG_W +: REG_W];
  assign gainGreen   = regFlat[3*REG_W +: REG_W];
  assign gainBlue    = regFlat[4*REG_W +: REG_W];
  assign offsetRed   = regFlat[5*REG_W +: REG_W];
  assign offsetGreen = regFlat[6*REG_W +: REG_W];
  assign offsetBlue  = regFlat[7*REG_W +: REG_W];

  assign modeCorrSample    = cfgReg[BIT_CORR];
  assign modeSpanWide      = cfgReg[BIT_WIDE];
  assign modeSpanNarrow    = cfgReg[BIT_NARROW];
  assign modeTriChannel    = cfgReg[BIT_TRI];
  assign modeSingleChannel = cfgReg[BIT_SINGLE];
endmodule

// File: tb/test_serreg_port.sv
`timescale 1ns/1ps
module test_serreg_port;
  localparam int HALF = 10;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic serClk = 1'b0, serLoad = 1'b1, serDataIn = 1'b0;
  logic serDataOut, serDataOe;
  logic [7:0] cfgReg, muxReg, gainRed, gainGreen, gainBlue, offsetRed, offsetGreen, offsetBlue;
  logic modeCorrSample, modeSpanWide, modeSpanNarrow, modeTriChannel, modeSingleChannel;

  int nChecks = 0, nFails = 0;
  bit done = 1'b0;
  logic [7:0] model [8];

  always #2.5 clk = ~clk;

  serreg_port i_serreg_port (
    .clk(clk), .rstN(rstN), .serClk(serClk), .serLoad(serLoad), .serDataIn(serDataIn),
    .serDataOut(serDataOut), .serDataOe(serDataOe),
    .cfgReg(cfgReg), .muxReg(muxReg), .gainRed(gainRed), .gainGreen(gainGreen),
    .gainBlue(gainBlue), .offsetRed(offsetRed), .offsetGreen(offsetGreen),
    .offsetBlue(offsetBlue), .modeCorrSample(modeCorrSample), .modeSpanWide(modeSpanWide),
    .modeSpanNarrow(modeSpanNarrow), .modeTriChannel(modeTriChannel),
    .modeSingleChannel(modeSingleChannel)
  );

  task automatic waitCycles(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic check(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    nChecks++;
    if (!ok) begin
      nFails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [63:0] observed();
    return {offsetBlue, offsetGreen, offsetRed, gainBlue, gainGreen, gainRed, muxReg, cfgReg};
  endfunction

  function automatic logic [63:0] expected();
    return {model[7], model[6], model[5], model[4], model[3], model[2], model[1], model[0]};
  endfunction

  task automatic checkRegs(input string req);
    check(observed() == expected(), req, observed(), expected());
  endtask

  task automatic checkDecode();
    logic [4:0] act, exp;
    act = {modeCorrSample, modeSpanWide, modeSpanNarrow, modeTriChannel, modeSingleChannel};
    exp = {model[0][5], model[0][4], model[0][3], model[0][2], model[0][1]};
    check(act == exp, "R9", 64'(act), 64'(exp));
  endtask

  task automatic runFrame(input bit rw, input logic [2:0] addr, input logic [7:0] data,
                          input int nPulses, input bit midCheck, output logic [7:0] rb);
    logic [15:0] bits;
    bit oeOk;
    bits = {rw, addr, 4'($urandom), data};
    rb = '0;
    oeOk = 1'b1;
    serLoad = 1'b0;
    waitCycles(HALF);
    for (int k = 1; k <= nPulses; k++) begin
      serDataIn = (k <= 16) ? bits[16-k] : 1'($urandom % 2);
      waitCycles(HALF);
      if (rw && k == 8)
        check(serDataOe == 1'b0, "R7 early drive", 64'(serDataOe), 64'd0);
      if (rw && k >= 9 && k <= 16) begin
        rb[16-k] = serDataOut;
        if (!serDataOe) oeOk = 1'b0;
      end
      serClk = 1'b1;
      waitCycles(HALF);
      serClk = 1'b0;
    end
    waitCycles(HALF);
    if (rw && nPulses >= 16)
      check(oeOk, "R7 drive window", 64'(oeOk), 64'd1);
    if (midCheck) checkRegs("R3 before frame end");
    serLoad = 1'b1;
    serDataIn = 1'b0;
    waitCycles(HALF);
    check(serDataOe == 1'b0, "R8", 64'(serDataOe), 64'd0);
    if (!rw && nPulses >= 16) model[addr] = data;
  endtask

  initial begin
    logic [7:0] rb;
    void'($urandom(32'd20240611));
    for (int i = 0; i < 8; i++) model[i] = 8'h00;
    model[0] = 8'h34;
    model[1] = 8'h21;
    waitCycles(5);
    rstN = 1'b1;
    waitCycles(5);

    // R1: reset state
    checkRegs("R1");
    check(serDataOe == 1'b0, "R1 oe", 64'(serDataOe), 64'd0);
    checkDecode();

    // R2 R3 R4: write green gain, hold until frame line rises
    runFrame(1'b0, 3'd3, 8'hA5, 16, 1'b1, rb);
    checkRegs("R4 R2 green gain write");

    // R7 R10: read it back
    runFrame(1'b1, 3'd3, 8'h00, 16, 1'b0, rb);
    check(rb == 8'hA5, "R7 readback", 64'(rb), 64'hA5);
    checkRegs("R10");

    // R7: default mux register read
    runFrame(1'b1, 3'd1, 8'h00, 16, 1'b0, rb);
    check(rb == 8'h21, "R7 mux readback", 64'(rb), 64'h21);

    // R5: extra pulses ignored
    runFrame(1'b0, 3'd7, 8'hFF, 20, 1'b0, rb);
    checkRegs("R5");

    // R6: partial frames discarded
    runFrame(1'b0, 3'd5, 8'h5A, 15, 1'b0, rb);
    checkRegs("R6 fifteen pulses");
    runFrame(1'b0, 3'd0, 8'h00, 3, 1'b0, rb);
    checkRegs("R6 three pulses");

    // R9: mode decode after a config write
    runFrame(1'b0, 3'd0, 8'h0A, 16, 1'b0, rb);
    checkRegs("R4 cfg write");
    checkDecode();

    // R4: every address
    for (int a = 0; a < 8; a++) begin
      runFrame(1'b0, 3'(a), 8'(8'h11 * (a + 1)), 16, 1'b0, rb);
      checkRegs("R4 address sweep");
    end

    // random mix
    for (int i = 0; i < 60; i++) begin
      bit rw;
      logic [2:0] a;
      logic [7:0] d;
      int sel, n;
      rw = 1'($urandom % 2);
      a = 3'($urandom);
      d = 8'($urandom);
      sel = int'($urandom % 8);
      if (sel < 5)      n = 16;
      else if (sel == 5) n = 17 + int'($urandom % 4);
      else              n = 4 + int'($urandom % 12);
      runFrame(rw, a, d, n, (!rw && n >= 16 && sel == 0), rb);
      if (rw && n >= 16)
        check(rb == model[a], "R7 random readback", 64'(rb), 64'(model[a]));
      checkRegs(rw ? "R10 random" : "R4 R5 R6 random");
      checkDecode();
    end

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      nChecks++;
      nFails++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
      $finish;
    end
  end
endmodule